// File: doc/BRIEF.md
# Signed Integer Divider Peripheral

This block is a register-mapped divider for a processor subsystem. Software loads a 64-bit dividend and a 64-bit divisor through a simple 32-bit word bus and picks an operand-width mode in a control word. Any write to an operand word or to the control word starts a new division. A busy bit stays set for a fixed number of clock cycles. Then the block stores a 64-bit quotient and a 64-bit remainder, each readable as two 32-bit words.

The arithmetic is signed. The quotient rounds toward zero, and the remainder carries the sign of the dividend. Two cases have fixed results and never trap: a zero divisor, and the most negative dividend divided by minus one. Each of these raises an error bit in the control word. The core is a restoring divider on magnitudes. It retires `STEP_BITS` quotient bits per clock, so the latency is 64/`STEP_BITS` + 2 cycles from the write.

Top module: `sdiv_mmio`

## Requirements
- R1: After a synchronous active-low reset, every readable word reads zero: the control word, both operands and both results.
- R2: Word addresses are: 0 control, 1 dividend low, 2 dividend high, 3 divisor low, 4 divisor high. Each operand word reads back the value last written to it. Addresses 9 to 15 read zero.
- R3: Control bits 1:0 select the mode. In mode 0, the low words of both operands are sign-extended to 64 bits and the high words are ignored. In modes 1 and 3, the dividend is the full 64 bits and the divisor is its sign-extended low word. In mode 2, both operands are the full 64 bits.
- R4: Control bit 15 (busy) reads 1 from the cycle after an operand or control write. It stays 1 for exactly 64/STEP_BITS + 2 cycles, and it clears in the same cycle that the results and bit 14 update.
- R5: A write to addresses 0 to 4 while busy abandons the division in progress. The results then reflect the operands as they stand after the last write, and the full latency counts from that last write.
- R6: When the effective divisor is zero, bit 14 is set, the remainder equals the effective dividend, and the quotient is 1 for a negative dividend and 0 otherwise.
- R7: When the effective divisor is -1 and the effective dividend is the most negative value of its width (32 bits in mode 0, 64 bits otherwise), bit 14 is set, the quotient equals the effective dividend and the remainder is 0.
- R8: In all other cases bit 14 is cleared, the quotient is truncated toward zero, and the remainder has the sign of the dividend.
- R9: The results are read as little-endian word pairs: quotient low at 5, quotient high at 6, remainder low at 7, remainder high at 8. Writes to addresses 5 to 15 change nothing and start nothing. Control bits 14 and 15 cannot be written.
- R10: While a division is pending, the result words and bit 14 keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
The bench builds the divider with STEP_BITS = 2, so each division takes 34 cycles. At this setting the stage generate loop has more than one stage, and a restart in the middle of a division falls between two multi-bit steps. It also keeps a run of about a hundred divisions short enough to sweep every mode with random operands against a signed reference model. The bench also counts busy cycles edge by edge, so a wrong stage count or iteration count shows up as a latency error.

// File: rtl/sdiv_pkg.sv
// Shared constants and types for the signed divider peripheral.
// Assumes a 32-bit bus and 64-bit arithmetic throughout.
package sdiv_pkg;
    localparam int OPW    = 64;
    localparam int BUSW   = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_NUM_LO = 4'd1;
    localparam logic [ADDR_W-1:0] A_NUM_HI = 4'd2;
    localparam logic [ADDR_W-1:0] A_DEN_LO = 4'd3;
    localparam logic [ADDR_W-1:0] A_DEN_HI = 4'd4;
    localparam logic [ADDR_W-1:0] A_QUO_LO = 4'd5;
    localparam logic [ADDR_W-1:0] A_QUO_HI = 4'd6;
    localparam logic [ADDR_W-1:0] A_REM_LO = 4'd7;
    localparam logic [ADDR_W-1:0] A_REM_HI = 4'd8;

    typedef enum logic [1:0] {
        W32_BY_32  = 2'd0,
        W64_BY_32  = 2'd1,
        W64_BY_64  = 2'd2,
        W64_BY_32B = 2'd3
    } width_mode_e;

    // Operands after width handling, with the flags for special cases.
    typedef struct packed {
        logic [OPW-1:0] num_eff;
        logic [OPW-1:0] den_eff;
        logic [OPW-1:0] num_mag;
        logic [OPW-1:0] den_mag;
        logic           num_neg;
        logic           den_neg;
        logic           den_zero;
        logic           ovf;
    } prep_t;
endpackage

// File: rtl/sdiv_prep.sv
// Operand conditioning: applies the width mode, sign-extends 32-bit operands,
// forms magnitudes and detects the zero-divisor and overflow cases.
// Purely combinational; assumes the raw operands are held stable while busy.
module sdiv_prep
    import sdiv_pkg::*;
(
    input  width_mode_e     mode,
    input  logic [OPW-1:0]  num_raw,
    input  logic [OPW-1:0]  den_raw,
    output prep_t           prep
);
    logic [OPW-1:0] num_e, den_e;
    logic           num_min;

    // Select the effective operands for the mode.
    always_comb begin
        num_e = (mode == W32_BY_32) ? {{(OPW/2){num_raw[OPW/2-1]}}, num_raw[OPW/2-1:0]} : num_raw;
        den_e = (mode == W64_BY_64) ? den_raw : {{(OPW/2){den_raw[OPW/2-1]}}, den_raw[OPW/2-1:0]};
    end

    // Detect the most negative dividend for the active width.
    always_comb begin
        if (mode == W32_BY_32)
            num_min = (num_e == {{(OPW/2+1){1'b1}}, {(OPW/2-1){1'b0}}});
        else
            num_min = (num_e == {1'b1, {(OPW-1){1'b0}}});
    end

    // Pack the conditioned operands and special-case flags.
    always_comb begin
        prep.num_eff  = num_e;
        prep.den_eff  = den_e;
        prep.num_neg  = num_e[OPW-1];
        prep.den_neg  = den_e[OPW-1];
        prep.num_mag  = num_e[OPW-1] ? (~num_e + 1'b1) : num_e;
        prep.den_mag  = den_e[OPW-1] ? (~den_e + 1'b1) : den_e;
        prep.den_zero = (den_e == '0);
        prep.ovf      = num_min && (den_e == '1);
    end
endmodule

// File: rtl/sdiv_core.sv
// Iterative unsigned restoring divider on 64-bit magnitudes. It retires
// STEP_BITS quotient bits per clock through a generated chain of stages.
// Assumes STEP_BITS divides 64. A load aborts any run in progress;
// done pulses for one cycle when the final quotient and remainder are held.
module sdiv_core
    import sdiv_pkg::*;
#(
    parameter int STEP_BITS = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [OPW-1:0] num_mag,
    input  logic [OPW-1:0] den_mag,
    output logic           done,
    output logic [OPW-1:0] uquo,
    output logic [OPW-1:0] urem
);
    localparam int ITER = OPW / STEP_BITS;
    localparam int CW   = $clog2(ITER + 1);

    logic [OPW:0]   rem_q;
    logic [OPW-1:0] quo_q;
    logic [OPW-1:0] den_q;
    logic [CW-1:0]  cnt_q;

    logic [OPW:0]   rem_st [STEP_BITS+1];
    logic [OPW-1:0] quo_st [STEP_BITS+1];

    assign rem_st[0] = rem_q;
    assign quo_st[0] = quo_q;

    // One shift-compare-subtract stage per retired quotient bit.
    for (genvar g = 0; g < STEP_BITS; g++) begin : g_stage
        logic [OPW:0] shifted;
        logic         fits;
        assign shifted       = {rem_st[g][OPW-1:0], quo_st[g][OPW-1]};
        assign fits          = (shifted >= {1'b0, den_q});
        assign rem_st[g+1]   = fits ? (shifted - {1'b0, den_q}) : shifted;
        assign quo_st[g+1]   = {quo_st[g][OPW-2:0], fits};
    end

    // Iteration state: load, step until the count runs out, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= num_mag;
            den_q <= den_mag;
            cnt_q <= CW'(ITER);
            done  <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q <= rem_st[STEP_BITS];
            quo_q <= quo_st[STEP_BITS];
            cnt_q <= cnt_q - CW'(1);
            done  <= (cnt_q == CW'(1));
        end else begin
            done  <= 1'b0;
        end
    end

    assign uquo = quo_q;
    assign urem = rem_q[OPW-1:0];
endmodule

// File: rtl/sdiv_fix.sv
// Result shaping: restores signs on the unsigned core output and substitutes
// the fixed results for a zero divisor and for most-negative by minus one.
// Combinational; assumes prep still describes the operands of this run.
module sdiv_fix
    import sdiv_pkg::*;
(
    input  prep_t          prep,
    input  logic [OPW-1:0] uquo,
    input  logic [OPW-1:0] urem,
    output logic [OPW-1:0] quo,
    output logic [OPW-1:0] rem,
    output logic           err
);
    // Choose between the special-case results and the sign-corrected ones.
    always_comb begin
        if (prep.den_zero) begin
            quo = {{(OPW-1){1'b0}}, prep.num_neg};
            rem = prep.num_eff;
            err = 1'b1;
        end else if (prep.ovf) begin
            quo = prep.num_eff;
            rem = '0;
            err = 1'b1;
        end else begin
            quo = (prep.num_neg ^ prep.den_neg) ? (~uquo + 1'b1) : uquo;
            rem = prep.num_neg ? (~urem + 1'b1) : urem;
            err = 1'b0;
        end
    end
endmodule

// File: rtl/sdiv_mmio.sv
// Register-mapped signed divider. It holds the operand and mode registers,
// starts the core on any operand or control write, and commits results.
// Assumes single-cycle write strobes and combinational reads.
module sdiv_mmio
    import sdiv_pkg::*;
#(
    parameter int STEP_BITS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUSW-1:0]   bus_wdata,
    output logic [BUSW-1:0]   bus_rdata
);
    width_mode_e    mode_q;
    logic [OPW-1:0] num_q, den_q, quot_q, rem_q;
    logic           busy_q, flag_q, start_q;
    logic           wr_start, commit, core_done;
    logic [OPW-1:0] uquo, urem, fquo, frem;
    logic           ferr;
    prep_t          prep;

    assign wr_start = bus_wr && (bus_addr <= A_DEN_HI);
    assign commit   = core_done && !start_q && !wr_start;

    sdiv_prep u_prep (
        .mode    (mode_q),
        .num_raw (num_q),
        .den_raw (den_q),
        .prep    (prep)
    );

    sdiv_core #(.STEP_BITS(STEP_BITS)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_q),
        .num_mag (prep.num_mag),
        .den_mag (prep.den_mag),
        .done    (core_done),
        .uquo    (uquo),
        .urem    (urem)
    );

    sdiv_fix u_fix (
        .prep (prep),
        .uquo (uquo),
        .urem (urem),
        .quo  (fquo),
        .rem  (frem),
        .err  (ferr)
    );

    // Operand and mode registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= W32_BY_32;
            num_q  <= '0;
            den_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:   mode_q              <= width_mode_e'(bus_wdata[1:0]);
                A_NUM_LO: num_q[BUSW-1:0]     <= bus_wdata;
                A_NUM_HI: num_q[OPW-1:BUSW]   <= bus_wdata;
                A_DEN_LO: den_q[BUSW-1:0]     <= bus_wdata;
                A_DEN_HI: den_q[OPW-1:BUSW]   <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Start pulse and busy flag sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            start_q <= wr_start;
            if (wr_start)    busy_q <= 1'b1;
            else if (commit) busy_q <= 1'b0;
        end
    end

    // Result registers, updated only when a run completes unabandoned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            rem_q  <= '0;
            flag_q <= 1'b0;
        end else if (commit) begin
            quot_q <= fquo;
            rem_q  <= frem;
            flag_q <= ferr;
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            A_CTRL:   bus_rdata = {16'd0, busy_q, flag_q, 12'd0, mode_q};
            A_NUM_LO: bus_rdata = num_q[BUSW-1:0];
            A_NUM_HI: bus_rdata = num_q[OPW-1:BUSW];
            A_DEN_LO: bus_rdata = den_q[BUSW-1:0];
            A_DEN_HI: bus_rdata = den_q[OPW-1:BUSW];
            A_QUO_LO: bus_rdata = quot_q[BUSW-1:0];
            A_QUO_HI: bus_rdata = quot_q[OPW-1:BUSW];
            A_REM_LO: bus_rdata = rem_q[BUSW-1:0];
            A_REM_HI: bus_rdata = rem_q[OPW-1:BUSW];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sdiv_chk.sv
// Assertion checker for sdiv_mmio, bound into every instance.
// It watches busy timing, result stability and special-case outcomes.
module sdiv_chk
    import sdiv_pkg::*;
#(
    parameter int STEP_BITS = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              busy_q,
    input logic              flag_q,
    input logic [1:0]        mode_q,
    input logic [OPW-1:0]    quot_q,
    input logic [OPW-1:0]    rem_q,
    input logic [OPW-1:0]    num_eff,
    input logic              den_zero,
    input logic              ovf
);
    localparam int LAT = OPW / STEP_BITS + 2;
    localparam int LW  = $clog2(LAT + 2) + 1;

    logic          wr_go;
    logic [LW-1:0] age;

    assign wr_go = bus_wr && (bus_addr <= A_DEN_HI);

    // Count the cycles since the most recent start.
    always_ff @(posedge clk) begin
        if (!rst_n)           age <= '0;
        else if (wr_go)       age <= LW'(1);
        else if (busy_q)      age <= age + LW'(1);
    end

    // R4
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> busy_q);

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && age < LW'(LAT)) |=> busy_q);

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && age == LW'(LAT) && !wr_go) |=> !busy_q);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |=> ($stable(quot_q) && $stable(rem_q) && $stable(flag_q)));

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_CTRL) |=> $stable(mode_q));

    // R6
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && den_zero) |-> (flag_q && rem_q == num_eff));

    // R7
    ovf_quo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && ovf) |-> (flag_q && quot_q == num_eff && rem_q == '0));

    // R8
    normal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_q) && !den_zero && !ovf) |-> !flag_q);
endmodule

bind sdiv_mmio sdiv_chk #(.STEP_BITS(STEP_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .busy_q   (busy_q),
    .flag_q   (flag_q),
    .mode_q   (mode_q),
    .quot_q   (quot_q),
    .rem_q    (rem_q),
    .num_eff  (prep.num_eff),
    .den_zero (prep.den_zero),
    .ovf      (prep.ovf)
);

// File: tb/tb_sdiv_mmio.sv
// Directed bench for sdiv_mmio: one task per scenario, each checking itself.
module tb_sdiv_mmio;
    localparam int STEP = 2;
    localparam int LAT  = 64 / STEP + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_run = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sdiv_mmio #(.STEP_BITS(STEP)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd64(input logic [3:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(a + 4'd1, hi);
        d = {hi, lo};
    endtask

    // Signed reference model written from the requirements.
    task automatic ref_div(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d,
                           output logic [63:0] q, output logic [63:0] r, output logic f);
        longint sn, sd;
        sn = (m == 2'd0) ? longint'({{32{n[31]}}, n[31:0]}) : longint'(n);
        sd = (m == 2'd2) ? longint'(d) : longint'({{32{d[31]}}, d[31:0]});
        if (sd == 0) begin
            f = 1'b1; r = sn; q = (sn < 0) ? 64'd1 : 64'd0;
        end else if (sd == -1 && ((m == 2'd0 && sn == -64'sd2147483648) ||
                                  (m != 2'd0 && sn == {1'b1, 63'd0}))) begin
            f = 1'b1; q = sn; r = 64'd0;
        end else begin
            f = 1'b0; q = sn / sd; r = sn % sd;
        end
    endtask

    task automatic load_ops(input logic [1:0] m, input logic [63:0] n, input logic [63:0] d);
        wr(4'd0, {30'd0, m});
        wr(4'd1, n[31:0]);
        wr(4'd2, n[63:32]);
        wr(4'd3, d[31:0]);
        wr(4'd4, d[63:32]);
    endtask

    task automatic run_and_check(input string req, input logic [1:0] m,
                                 input logic [63:0] n, input logic [63:0] d);
        logic [63:0] q, r, eq, er;
        logic [31:0] c;
        logic        ef;
        load_ops(m, n, d);
        repeat (LAT) @(negedge clk);
        ref_div(m, n, d, eq, er, ef);
        rd64(4'd5, q);
        rd64(4'd7, r);
        rd(4'd0, c);
        check({req, " quotient"}, q, eq);
        check({req, " remainder"}, r, er);
        check({req, " bit14"}, {63'd0, c[14]}, {63'd0, ef});
        check({req, " busy clear"}, {63'd0, c[15]}, 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d);
            check("R1 reset word", {32'd0, d}, 64'd0);
        end
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(4'd1, 32'hA1B2C3D4);
        wr(4'd2, 32'h01020304);
        wr(4'd3, 32'h0BADF00D);
        wr(4'd4, 32'hCAFE0001);
        repeat (LAT) @(negedge clk);
        rd(4'd1, d); check("R2 dividend low", {32'd0, d}, 64'hA1B2C3D4);
        rd(4'd2, d); check("R2 dividend high", {32'd0, d}, 64'h01020304);
        rd(4'd3, d); check("R2 divisor low", {32'd0, d}, 64'h0BADF00D);
        rd(4'd4, d); check("R2 divisor high", {32'd0, d}, 64'hCAFE0001);
        rd(4'd12, d); check("R2 unmapped", {32'd0, d}, 64'd0);
    endtask

    task automatic t_modes();
        run_and_check("R3 mode0", 2'd0, 64'h12345678_FFFFFF9C, 64'h0000DEAD_00000007);
        run_and_check("R3 mode1", 2'd1, -64'sd1000000000000, 64'h00000005_FFFFFFFD);
        run_and_check("R3 mode3", 2'd3, -64'sd1000000000000, 64'h00000005_FFFFFFFD);
        run_and_check("R3 mode2", 2'd2, 64'sd1000000000000, 64'h00000001_00000000);
    endtask

    task automatic t_latency();
        logic [31:0] c;
        logic [63:0] q0, q;
        run_and_check("R4 setup", 2'd2, 64'd1000, 64'd7);
        rd64(4'd5, q0);
        wr(4'd1, 32'd5000);
        rd(4'd0, c);  check("R4 busy after write", {63'd0, c[15]}, 64'd1);
        rd64(4'd5, q); check("R10 quotient held while busy", q, q0);
        repeat (LAT - 1) @(negedge clk);
        rd(4'd0, c);  check("R4 busy on last cycle", {63'd0, c[15]}, 64'd1);
        rd64(4'd5, q); check("R10 quotient held on last cycle", q, q0);
        @(negedge clk);
        rd(4'd0, c);  check("R4 busy clears", {63'd0, c[15]}, 64'd0);
        rd64(4'd5, q); check("R4 quotient updates", q, 64'd714);
    endtask

    task automatic t_zero();
        run_and_check("R6 negative by zero", 2'd2, -64'sd5, 64'd0);
        run_and_check("R6 positive by zero", 2'd1, 64'd5, 64'hFFFF0000_00000000);
        run_and_check("R6 mode0 low zero", 2'd0, 64'h00000000_80000001, 64'h12345678_00000000);
    endtask

    task automatic t_overflow();
        run_and_check("R7 mode0 min", 2'd0, 64'h00000000_80000000, 64'h00000000_FFFFFFFF);
        run_and_check("R7 mode2 min", 2'd2, 64'h80000000_00000000, 64'hFFFFFFFF_FFFFFFFF);
        run_and_check("R7 mode1 min", 2'd1, 64'h80000000_00000000, 64'h00000000_FFFFFFFF);
        run_and_check("R8 mode1 32-bit min not overflow", 2'd1, 64'hFFFFFFFF_80000000, 64'h0_FFFFFFFF);
    endtask

    task automatic t_random();
        for (int i = 0; i < 90; i++) begin
            logic [1:0]  m;
            logic [63:0] n, d;
            m = 2'($urandom_range(0, 3));
            n = {$urandom, $urandom};
            d = {$urandom, $urandom};
            if (i % 3 == 1) d = {{48{d[15]}}, d[15:0]};
            if (i % 5 == 2) n = {{40{n[23]}}, n[23:0]};
            run_and_check("R8 random", m, n, d);
        end
    endtask

    task automatic t_restart();
        logic [31:0] c;
        logic [63:0] q;
        load_ops(2'd2, 64'd999, 64'd3);
        repeat (LAT / 2) @(negedge clk);
        wr(4'd1, 32'd600);
        repeat (LAT - 1) @(negedge clk);
        rd(4'd0, c);  check("R5 still busy after restart", {63'd0, c[15]}, 64'd1);
        @(negedge clk);
        rd(4'd0, c);  check("R5 busy clears after restart", {63'd0, c[15]}, 64'd0);
        rd64(4'd5, q); check("R5 latest dividend used", q, 64'd200);
    endtask

    task automatic t_readonly();
        logic [31:0] c, d;
        logic [63:0] q;
        run_and_check("R9 setup", 2'd2, 64'h11223344_55667788, 64'd1);
        rd(4'd5, d); check("R9 quotient low word", {32'd0, d}, 64'h55667788);
        rd(4'd6, d); check("R9 quotient high word", {32'd0, d}, 64'h11223344);
        wr(4'd5, 32'hFFFFFFFF);
        wr(4'd8, 32'hFFFFFFFF);
        rd(4'd0, c);  check("R9 result write starts nothing", {63'd0, c[15]}, 64'd0);
        rd64(4'd5, q); check("R9 quotient not writable", q, 64'h11223344_55667788);
        rd64(4'd7, q); check("R9 remainder not writable", q, 64'd0);
        wr(4'd0, 32'h00004002);
        repeat (LAT) @(negedge clk);
        rd(4'd0, c);  check("R9 control write keeps only mode", {32'd0, c}, 64'h00000002);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_modes();
        t_latency();
        t_zero();
        t_overflow();
        t_restart();
        t_readonly();
        t_random();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule